// File: doc/BRIEF.md
# Set/Clear GPIO Register Controller

This block is a general-purpose I/O controller for a bank of lines equal in number to its register width, with bit n of every register belonging to line n. It sits on a plain parallel register bus with separate read and write strobes. Software reads the synchronized pin levels and drives an output latch through write-one-to-set and write-one-to-clear registers. A per-line direction bit can be written either as an output mask or as an input mask.

Build-time parameters choose which of the set, clear, direction-out and direction-in registers exist. They also choose whether the block may drive pins at all, and whether bus data is byte-swapped for a big-endian host. A missing register changes the meaning of the remaining ones:
- Without a clear register, a set write replaces the whole latch.
- Without a set register, a data write loads the latch.
- Without any direction register, every line is a fixed output.

The bus has no back-pressure. Every strobe is accepted in the cycle it is presented. A read answers exactly one cycle later with `rd_valid` high for one cycle. The requester must not depend on any other timing. A read and a write in the same cycle are both carried out, and the read returns the state from before the write.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After reset the output latch is all zeros, `rd_valid` is low, and when a direction register exists every line is an input: `gpio_oe` is zero, direction-out reads 0 and direction-in reads all ones.
- R2: A data read (offset 0) returns 1 for each high input line and 0 for each low one, taken through a two-flop synchronizer. A read strobed at the first or second rising edge after an input change still returns the old level, and a read strobed at the third edge returns the new level.
- R3: With both set and clear present, writing 1 to a bit of the set register (offset 1) drives that line high and leaves the other bits unchanged. In that case, data-register writes do not touch the latch.
- R4: Writing 1 to a bit of the clear register (offset 2) drives that line low and leaves the other bits unchanged.
- R5: With no clear register, a set write loads the latch directly, so bits written as 0 drive their lines low.
- R6: The direction bit is 1 for output and 0 for input. A direction-out write (offset 3) loads the bit, and a direction-in write (offset 4) loads its inverse. Direction-out reads back the bit and direction-in reads back its inverse. With neither direction register present, all lines are fixed outputs.
- R7: With no set register, a data write loads the output latch, and a clear write still clears bits.
- R8: `rd_valid` goes high for exactly the one cycle after a read strobe. Set and clear reads return the current output latch.
- R9: With the no-output option, `gpio_oe` stays zero and writes to data, set, clear or direction leave the latch and set readback at zero.
- R10: With big-endian selected, byte k of the bus word maps to byte (N-1-k) of the register, for both writes and reads.
- R11: Offsets 5 to 7, and the offsets of registers left out of the build, ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | WIDTH | Write data in bus byte order |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | WIDTH | Read data in bus byte order |
| gpio_in | input | WIDTH | Pin levels, asynchronous |
| gpio_out | output | WIDTH | Output latch value |
| gpio_oe | output | WIDTH | Per-line driver enable |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable at the rising edge whenever a strobe is high. They also assume that `gpio_in` holds for at least two edges, so that the synchronizer delay can be compared against the raw pin history. The bench drives every bus field and pin on the falling edge and drops the strobes one cycle later. Pin levels are changed only between complete operations, so both assumptions hold in every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_a, stage_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= '0;
      stage_b <= '0;
    end else begin
      stage_a <= pin_raw;
      stage_b <= stage_a;
    end
  end

  assign pin_sync = stage_b;

  // warm-up counter so the two-edge history never reaches before reset
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  p_sync_two_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 2'd2) |-> (pin_sync == $past(pin_raw, 2)));
endmodule

// File: rtl/gpio_latch_bank.sv
module gpio_latch_bank
  import gpio_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter bit HAS_SET   = 1'b1,
  parameter bit HAS_CLR   = 1'b1,
  parameter bit HAS_DOUT  = 1'b1,
  parameter bit HAS_DIN   = 1'b1,
  parameter bit NO_OUTPUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q
);
  localparam bit FIXED_DIR = !HAS_DOUT && !HAS_DIN;

  logic [WIDTH-1:0] out_nxt;

  always_comb begin
    out_nxt = out_q;
    if (wr_en && !NO_OUTPUT) begin
      case (wr_addr)
        OFS_DATA: if (!HAS_SET) out_nxt = wr_data;
        OFS_SET:  if (HAS_SET)  out_nxt = HAS_CLR ? (out_q | wr_data) : wr_data;
        OFS_CLR:  if (HAS_CLR)  out_nxt = out_q & ~wr_data;
        default:  out_nxt = out_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_nxt;
  end

  if (FIXED_DIR) begin : g_fixed_dir
    assign dir_q = NO_OUTPUT ? '0 : '1;
  end else begin : g_dir_reg
    logic [WIDTH-1:0] dir_nxt;
    logic [WIDTH-1:0] dir_r;
    always_comb begin
      dir_nxt = dir_r;
      if (wr_en && !NO_OUTPUT) begin
        if (HAS_DOUT && wr_addr == OFS_DOUT) dir_nxt = wr_data;
        if (HAS_DIN && wr_addr == OFS_DIN)   dir_nxt = ~wr_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_r <= '0;
      else        dir_r <= dir_nxt;
    end
    assign dir_q = dir_r;
  end

  if (HAS_SET && HAS_CLR && !NO_OUTPUT) begin : g_chk_set
    p_set_drives_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_SET) |=> ((out_q & $past(wr_data)) == $past(wr_data)));
  end
  if (HAS_CLR && !NO_OUTPUT) begin : g_chk_clr
    p_clr_drives_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_CLR) |=> ((out_q & $past(wr_data)) == '0));
  end
  if (NO_OUTPUT) begin : g_chk_frozen
    p_writes_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ($stable(out_q) && $stable(dir_q)));
  end
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter bit HAS_SET  = 1'b1,
  parameter bit HAS_CLR  = 1'b1,
  parameter bit HAS_DOUT = 1'b1,
  parameter bit HAS_DIN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WIDTH-1:0]  pin_sync,
  input  logic [WIDTH-1:0]  out_q,
  input  logic [WIDTH-1:0]  dir_q,
  output logic              rd_valid,
  output logic [WIDTH-1:0]  rd_word
);
  logic [WIDTH-1:0] sel_word;

  always_comb begin
    case (rd_addr)
      OFS_DATA: sel_word = pin_sync;
      OFS_SET:  sel_word = HAS_SET  ? out_q  : '0;
      OFS_CLR:  sel_word = HAS_CLR  ? out_q  : '0;
      OFS_DOUT: sel_word = HAS_DOUT ? dir_q  : '0;
      OFS_DIN:  sel_word = HAS_DIN  ? ~dir_q : '0;
      default:  sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_word <= sel_word;
    end
  end

  p_unmapped_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > OFS_DIN) |=> (rd_valid && rd_word == '0));
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter bit HAS_SET    = 1'b1,
  parameter bit HAS_CLR    = 1'b1,
  parameter bit HAS_DOUT   = 1'b1,
  parameter bit HAS_DIN    = 1'b1,
  parameter bit NO_OUTPUT  = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] gpio_in,
  output logic [WIDTH-1:0] gpio_out,
  output logic [WIDTH-1:0] gpio_oe
);
  localparam int NBYTES = WIDTH / 8;
  localparam bit SWAP   = BIG_ENDIAN && (WIDTH % 8 == 0) && (NBYTES > 1);

  logic [WIDTH-1:0] wdata_le, rword_le, pin_sync, out_q, dir_q;

  if (SWAP) begin : g_swap
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign wdata_le[8*b +: 8] = bus_wdata[8*(NBYTES-1-b) +: 8];
      assign rd_data[8*b +: 8]  = rword_le[8*(NBYTES-1-b) +: 8];
    end
  end else begin : g_noswap
    assign wdata_le = bus_wdata;
    assign rd_data  = rword_le;
  end

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(gpio_in), .pin_sync(pin_sync)
  );

  gpio_latch_bank #(
    .WIDTH(WIDTH), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
    .HAS_DOUT(HAS_DOUT), .HAS_DIN(HAS_DIN), .NO_OUTPUT(NO_OUTPUT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(wdata_le), .out_q(out_q), .dir_q(dir_q)
  );

  gpio_read_port #(
    .WIDTH(WIDTH), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
    .HAS_DOUT(HAS_DOUT), .HAS_DIN(HAS_DIN)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .rd_addr(bus_addr),
    .pin_sync(pin_sync), .out_q(out_q), .dir_q(dir_q),
    .rd_valid(rd_valid), .rd_word(rword_le)
  );

  assign gpio_out = out_q;
  assign gpio_oe  = NO_OUTPUT ? '0 : dir_q;

  if (HAS_DIN) begin : g_chk_din
    p_dirin_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == OFS_DIN) |=> (rword_le == ~$past(dir_q)));
  end
  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);
  if (NO_OUTPUT) begin : g_chk_nodrive
    p_never_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gpio_oe == '0) && (gpio_out == '0));
  end
endmodule

// File: tb/tb_gpio_setclr_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_setclr_ctrl;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] gpio_in = 32'hA5A5_0F0F;

  logic rv_a, rv_b, rv_c, rv_d;
  logic [W-1:0] rd_a, rd_b, rd_c, rd_d;
  logic [W-1:0] out_a, out_b, out_c, out_d;
  logic [W-1:0] oe_a, oe_b, oe_c, oe_d;

  always #2.5 clk = ~clk;

  gpio_setclr_ctrl #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rv_a), .rd_data(rd_a), .gpio_in(gpio_in),
    .gpio_out(out_a), .gpio_oe(oe_a));

  gpio_setclr_ctrl #(.WIDTH(W), .HAS_CLR(1'b0), .HAS_DIN(1'b0), .BIG_ENDIAN(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rv_b), .rd_data(rd_b), .gpio_in(gpio_in),
    .gpio_out(out_b), .gpio_oe(oe_b));

  gpio_setclr_ctrl #(.WIDTH(W), .HAS_SET(1'b0), .HAS_DOUT(1'b0), .HAS_DIN(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rv_c), .rd_data(rd_c), .gpio_in(gpio_in),
    .gpio_out(out_c), .gpio_oe(oe_c));

  gpio_setclr_ctrl #(.WIDTH(W), .NO_OUTPUT(1'b1)) dut_d (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rv_d), .rd_data(rd_d), .gpio_in(gpio_in),
    .gpio_out(out_d), .gpio_oe(oe_d));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic rd, input logic [2:0] addr, input logic [W-1:0] data);
    @(negedge clk);
    bus_wr = !rd; bus_rd = rd; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  typedef struct packed {
    logic         rd;
    logic [2:0]   addr;
    logic [W-1:0] data;
    logic [W-1:0] exp_out;
    logic [W-1:0] exp_oe;
    logic [W-1:0] exp_rd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd1, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000, 32'h0},
    '{1'b0, 3'd1, 32'h0000_000F, 32'h0000_00FF, 32'h0000_0000, 32'h0},
    '{1'b0, 3'd2, 32'h0000_0030, 32'h0000_00CF, 32'h0000_0000, 32'h0},
    '{1'b1, 3'd1, 32'h0,         32'h0000_00CF, 32'h0000_0000, 32'h0000_00CF},
    '{1'b0, 3'd3, 32'h0000_FF00, 32'h0000_00CF, 32'h0000_FF00, 32'h0},
    '{1'b1, 3'd4, 32'h0,         32'h0000_00CF, 32'h0000_FF00, 32'hFFFF_00FF},
    '{1'b0, 3'd4, 32'h0000_0F00, 32'h0000_00CF, 32'hFFFF_F0FF, 32'h0},
    '{1'b1, 3'd3, 32'h0,         32'h0000_00CF, 32'hFFFF_F0FF, 32'hFFFF_F0FF},
    '{1'b1, 3'd0, 32'h0,         32'h0000_00CF, 32'hFFFF_F0FF, 32'hA5A5_0F0F},
    '{1'b0, 3'd0, 32'hFFFF_FFFF, 32'h0000_00CF, 32'hFFFF_F0FF, 32'h0},
    '{1'b0, 3'd6, 32'hFFFF_FFFF, 32'h0000_00CF, 32'hFFFF_F0FF, 32'h0},
    '{1'b1, 3'd6, 32'h0,         32'h0000_00CF, 32'hFFFF_F0FF, 32'h0},
    '{1'b1, 3'd2, 32'h0,         32'h0000_00CF, 32'hFFFF_F0FF, 32'h0000_00CF}
  };
  string tags [NV] = '{"R3", "R3", "R4", "R8", "R6", "R6", "R6", "R6", "R2",
                       "R3", "R11", "R11", "R8"};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", out_a, '0);
    check("R1 oe", oe_a, '0);
    check("R1 rd_valid", {31'b0, rv_a}, '0);
    bus_op(1'b1, 3'd3, '0);
    check("R1 dirout read", rd_a, '0);
    bus_op(1'b1, 3'd4, '0);
    check("R1 dirin read", rd_a, '1);

    // vector table on the fully populated instance
    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].rd, VECS[i].addr, VECS[i].data);
      check({tags[i], " out"}, out_a, VECS[i].exp_out);
      check({tags[i], " oe"}, oe_a, VECS[i].exp_oe);
      if (VECS[i].rd) begin
        check({tags[i], " rd_valid"}, {31'b0, rv_a}, 32'd1);
        check({tags[i], " rd_data"}, rd_a, VECS[i].exp_rd);
      end
    end
    @(negedge clk);
    check("R8 rd_valid drop", {31'b0, rv_a}, '0);

    // R2 synchronizer delay: change pins, then read three times in a row
    @(negedge clk);
    gpio_in = 32'h5A5A_F0F0;
    bus_rd = 1'b1; bus_addr = 3'd0;
    @(negedge clk);
    check("R2 first read old", rd_a, 32'hA5A5_0F0F);
    @(negedge clk);
    check("R2 second read old", rd_a, 32'hA5A5_0F0F);
    @(negedge clk);
    check("R2 third read new", rd_a, 32'h5A5A_F0F0);
    bus_rd = 1'b0;

    // R5 / R10 on big-endian instance without clear
    bus_op(1'b0, 3'd1, 32'h1122_3344);
    check("R10 swapped write", out_b, 32'h4433_2211);
    bus_op(1'b0, 3'd1, 32'h0000_00FF);
    check("R5 set replaces latch", out_b, 32'hFF00_0000);
    bus_op(1'b1, 3'd1, '0);
    check("R10 swapped read", rd_b, 32'h0000_00FF);
    bus_op(1'b0, 3'd3, 32'h0F00_0000);
    check("R10 dirout swapped", oe_b, 32'h0000_000F);
    bus_op(1'b0, 3'd4, 32'hFFFF_FFFF);
    check("R11 absent dirin write ignored", oe_b, 32'h0000_000F);
    bus_op(1'b1, 3'd4, '0);
    check("R11 absent dirin reads zero", rd_b, '0);

    // R7 / R6 fixed direction on instance without set and direction registers
    bus_op(1'b0, 3'd0, 32'h0000_1234);
    check("R7 data write loads latch", out_c, 32'h0000_1234);
    check("R6 fixed outputs", oe_c, '1);
    bus_op(1'b0, 3'd2, 32'h0000_0004);
    check("R7 clear still clears", out_c, 32'h0000_1230);

    // R9 no-output instance after all the writes above
    bus_op(1'b0, 3'd1, 32'hFFFF_FFFF);
    check("R9 latch stays zero", out_d, '0);
    check("R9 oe stays zero", oe_d, '0);
    bus_op(1'b1, 3'd1, '0);
    check("R9 set readback zero", rd_d, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule